// File: doc/BRIEF.md
# Shared Descriptor Queue Allocator

This block holds a small pool of on-chip descriptor queues. Many more receive and transmit descriptor rings live in system memory, so the pool is lent out as needed. A context engine asks for descriptors on behalf of an interface. If a queue already serves that interface, the request is a hit. If not, the allocator takes a queue for it and fills the queue through a memory read port, one descriptor per read. It prefers a free queue, then an idle one, then one owned by a lower-priority interface. A queue taken from another owner is flushed, and the ring position that owner had reached is reported so that its next fetch resumes in the right place. Interfaces marked real-time keep their queue for good, and the queue is topped up whenever a slot frees. Other queues are refilled only when their level drops to a threshold carried by the request. A scheduler pops descriptors by interface number.

Interface numbers carry no direction. Receive-only and transmit-only rings are served in any mix, and each ring is simply one interface number.

Top module: `desc_queue_alloc`

## Requirements
- R1: After reset no queue is held. `pop_valid`, `req_ack`, `req_busy`, `flush_valid` and `mem_rd_en` are all low.
- R2: If a request names an interface that no queue holds and a queue is free, `req_ack` rises in the same cycle, `flush_valid` stays low, and the free queue is taken at the next clock edge. No interface is ever held by two queues.
- R3: A queue that has just been taken is filled through single-descriptor reads. Each `mem_rd_en` lasts one cycle and carries the interface and a ring index. The first read uses the request's start index, and each later read adds one. A queue never holds more than 8 descriptors.
- R4: `pop_valid` is high while the interface on `pop_if` is held and its queue is not empty. `pop_desc` shows the oldest descriptor, and `pop_en` removes it. Descriptors come out in the order they were read.
- R5: A request for an interface that is already held is acknowledged in the same cycle with no flush. It adds `req_avail` to the ring's remaining count and replaces the threshold and priority.
- R6: A queue that is not real-time is refilled only when its level is at or below its threshold and the ring still has descriptors. One refill reads the smaller of the free slots and the remaining count.
- R7: A real-time queue is refilled whenever it holds fewer than 8 descriptors and its ring has some left, whatever its threshold.
- R8: A queue taken for a real-time request is never given to another interface.
- R9: When no queue holds the interface, the queue to take is chosen in this order:
  - a free queue;
  - otherwise an inactive queue, meaning not real-time, empty and not being filled (lowest index first);
  - otherwise a non-real-time queue that is not being filled and whose priority value is strictly below the request's. The lowest value wins, and ties go to the lowest index.
  A larger priority value means more important.
- R10: When a held queue is taken, `flush_valid` rises together with `req_ack`. `flush_if` names the previous owner and `flush_idx` gives the ring index of its first descriptor that was never popped, i.e. start index plus descriptors popped.
- R11: If no queue is eligible, `req_busy` is high and `req_ack` low. The request is then held, and it is acknowledged once a queue becomes eligible.
- R12: The total number of descriptors read for an interface never exceeds the available counts its requests supplied.
- R13: A pop for an interface that is not held, or whose queue is empty, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Descriptor request, held until acknowledged |
| req_if | input | 3 | Interface (ring) number |
| req_rt | input | 1 | Interface is real-time |
| req_prio | input | 2 | Priority, larger is more important |
| req_thresh | input | 4 | Refill threshold level |
| req_start | input | 16 | Ring index of first descriptor to fetch (used on allocation) |
| req_avail | input | 8 | Descriptors available in the ring |
| req_ack | output | 1 | Request accepted this cycle |
| req_busy | output | 1 | Request waiting for a queue |
| flush_valid | output | 1 | A held queue is reassigned this cycle |
| flush_if | output | 3 | Interface whose queue is flushed |
| flush_idx | output | 16 | Ring index to resume from for that interface |
| mem_rd_en | output | 1 | Single-descriptor read strobe |
| mem_rd_if | output | 3 | Interface of the read |
| mem_rd_idx | output | 16 | Ring index of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Descriptor returned |
| pop_en | input | 1 | Remove the head descriptor of `pop_if` |
| pop_if | input | 3 | Interface to pop from |
| pop_valid | output | 1 | `pop_if` is held and has a descriptor |
| pop_desc | output | 32 | Head descriptor for `pop_if` |

## Verification
The assertions rest on these assumptions about the inputs:
- Exactly one `mem_rd_valid` returns for each read strobe, and only after that strobe.
- A request stays steady until it is acknowledged.
- The scheduler never pops the interface that is about to lose its queue in the cycle the queue is reassigned.

The stimulus keeps to these rules. A memory model answers each strobe with a single response two edges later. Request inputs change only on the falling edge after an acknowledge. The pops that make a queue inactive finish before the cycle in which the waiting request is granted.

// File: rtl/dqa_pkg.sv
// Shared types for the descriptor queue allocator.
package dqa_pkg;
    // States of the descriptor fetch engine.
    typedef enum logic [1:0] {
        FE_IDLE  = 2'd0,
        FE_ISSUE = 2'd1,
        FE_WAIT  = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/dqa_queue.sv
// One on-chip descriptor queue with its ownership record.
// What it does: stores up to DEPTH descriptors as a FIFO, remembers the owning
// interface, its priority, threshold and real-time flag, the next ring index to
// fetch and the number of ring descriptors still to fetch.
// Assumes: wr_en never arrives when full (the fetch engine bounds its reads),
// and alloc_en has precedence over every other update in its cycle.
module dqa_queue #(
    parameter int DEPTH  = 8,
    parameter int DESC_W = 32,
    parameter int IF_W   = 3,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = 16,
    parameter int AV_W   = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              hit_en,
    input  logic [IF_W-1:0]   cfg_if,
    input  logic              cfg_rt,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [LVL_W-1:0]  cfg_thresh,
    input  logic [IDX_W-1:0]  cfg_start,
    input  logic [AV_W-1:0]   cfg_avail,
    input  logic              wr_en,
    input  logic [DESC_W-1:0] wr_data,
    input  logic              pop_en,
    output logic              owned,
    output logic [IF_W-1:0]   owner,
    output logic              is_rt,
    output logic [PRIO_W-1:0] prio,
    output logic [LVL_W-1:0]  level,
    output logic [AV_W-1:0]   remaining,
    output logic [IDX_W-1:0]  next_idx,
    output logic [DESC_W-1:0] head_data,
    output logic              need_refill
);
    localparam logic [LVL_W-1:0] FULL  = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LASTP = PTR_W'(DEPTH - 1);

    logic [DESC_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  thresh;
    logic              pop_do;
    logic [AV_W-1:0]   rem_dec;
    logic [AV_W:0]     rem_sum;
    logic [AV_W-1:0]   rem_next;

    // Pop takes effect only on a non-empty queue.
    assign pop_do = pop_en && (level != '0);

    // Remaining count after this cycle's write and any added availability.
    always_comb begin
        rem_dec  = remaining - (wr_en ? AV_W'(1) : AV_W'(0));
        rem_sum  = {1'b0, rem_dec} + {1'b0, cfg_avail};
        rem_next = hit_en ? (rem_sum[AV_W] ? '1 : rem_sum[AV_W-1:0]) : rem_dec;
    end

    // Ownership, counters and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owned     <= 1'b0;
            owner     <= '0;
            is_rt     <= 1'b0;
            prio      <= '0;
            thresh    <= '0;
            level     <= '0;
            remaining <= '0;
            next_idx  <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
        end else if (alloc_en) begin
            owned     <= 1'b1;
            owner     <= cfg_if;
            is_rt     <= cfg_rt;
            prio      <= cfg_prio;
            thresh    <= cfg_thresh;
            level     <= '0;
            remaining <= cfg_avail;
            next_idx  <= cfg_start;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
        end else begin
            if (hit_en) begin
                prio   <= cfg_prio;
                thresh <= cfg_thresh;
            end
            remaining <= rem_next;
            if (wr_en) begin
                wr_ptr   <= (wr_ptr == LASTP) ? '0 : wr_ptr + PTR_W'(1);
                next_idx <= next_idx + IDX_W'(1);
            end
            if (pop_do) begin
                rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + PTR_W'(1);
            end
            level <= level + (wr_en ? LVL_W'(1) : LVL_W'(0))
                           - (pop_do ? LVL_W'(1) : LVL_W'(0));
        end
    end

    // Descriptor storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en && !alloc_en) store[wr_ptr] <= wr_data;
    end

    assign head_data = store[rd_ptr];

    // Refill request: real-time queues stay full, others wait for the threshold.
    assign need_refill = owned && (remaining != '0) && (level < FULL)
                         && (is_rt || (level <= thresh));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (level < FULL));

    assert_pop_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && (level == '0) && !wr_en && !alloc_en) |=> (level == '0));

    assert_rt_pinned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && is_rt) |-> !alloc_en);
endmodule

// File: rtl/dqa_victim_sel.sv
// Queue selection for an incoming request.
// What it does: finds the queue already holding the requested interface, or
// else the queue to take, preferring free, then inactive, then the lowest
// strictly-lower priority owner; real-time and filling queues are never taken.
// Assumes: request fields are stable while req is evaluated (pure combinational).
module dqa_victim_sel #(
    parameter int NQ     = 4,
    parameter int IF_W   = 3,
    parameter int PRIO_W = 2,
    parameter int LVL_W  = 4,
    localparam int Q_W   = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NQ-1:0]             owned,
    input  logic [NQ-1:0]             is_rt,
    input  logic [NQ-1:0]             filling,
    input  logic [NQ-1:0][IF_W-1:0]   owner,
    input  logic [NQ-1:0][PRIO_W-1:0] prio,
    input  logic [NQ-1:0][LVL_W-1:0]  level,
    input  logic [IF_W-1:0]           req_if,
    input  logic [PRIO_W-1:0]         req_prio,
    output logic                      hit,
    output logic [Q_W-1:0]            hit_q,
    output logic                      alloc_ok,
    output logic [Q_W-1:0]            alloc_q
);
    logic           f_free, f_inact, f_low;
    logic [Q_W-1:0] q_free, q_inact, q_low;
    logic [PRIO_W-1:0] best_prio;

    // Scan all queues once for each selection class.
    always_comb begin
        hit = 1'b0;  hit_q = '0;
        f_free = 1'b0;  q_free = '0;
        f_inact = 1'b0; q_inact = '0;
        f_low = 1'b0;   q_low = '0;  best_prio = '0;
        for (int q = 0; q < NQ; q++) begin
            if (!hit && owned[q] && (owner[q] == req_if)) begin
                hit = 1'b1;  hit_q = Q_W'(q);
            end
            if (!f_free && !owned[q]) begin
                f_free = 1'b1;  q_free = Q_W'(q);
            end
            if (!f_inact && owned[q] && !is_rt[q] && !filling[q] && (level[q] == '0)) begin
                f_inact = 1'b1;  q_inact = Q_W'(q);
            end
            if (owned[q] && !is_rt[q] && !filling[q] && (prio[q] < req_prio)
                && (!f_low || (prio[q] < best_prio))) begin
                f_low = 1'b1;  q_low = Q_W'(q);  best_prio = prio[q];
            end
        end
        alloc_ok = f_free || f_inact || f_low;
        alloc_q  = f_free ? q_free : (f_inact ? q_inact : q_low);
    end
endmodule

// File: rtl/dqa_fetch_eng.sv
// Descriptor fetch engine shared by all queues.
// What it does: picks a queue asking for a refill (real-time first, then lowest
// index), sizes the burst as min(free slots, ring remaining) and reads one
// descriptor at a time, writing each returned descriptor into that queue.
// Assumes: exactly one mem_rd_valid returns per mem_rd_en, after it.
module dqa_fetch_eng
    import dqa_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int DEPTH  = 8,
    parameter int IF_W   = 3,
    parameter int IDX_W  = 16,
    parameter int AV_W   = 8,
    parameter int LVL_W  = 4,
    localparam int Q_W   = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic [NQ-1:0]            need_refill,
    input  logic [NQ-1:0]            is_rt,
    input  logic [NQ-1:0][LVL_W-1:0] level,
    input  logic [NQ-1:0][AV_W-1:0]  remaining,
    input  logic [NQ-1:0][IDX_W-1:0] next_idx,
    input  logic [NQ-1:0][IF_W-1:0]  owner,
    input  logic                     mem_rd_valid,
    output logic                     mem_rd_en,
    output logic [IF_W-1:0]          mem_rd_if,
    output logic [IDX_W-1:0]         mem_rd_idx,
    output logic [NQ-1:0]            wr_sel,
    output logic [NQ-1:0]            filling
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    fetch_state_e     state;
    logic [Q_W-1:0]   tgt;
    logic [LVL_W-1:0] cnt;
    logic             pick_ok;
    logic [Q_W-1:0]   pick_q;
    logic [LVL_W-1:0] space, burst;

    // Choose the next queue to refill: real-time queues win, then lowest index.
    always_comb begin
        pick_ok = 1'b0;
        pick_q  = '0;
        for (int q = 0; q < NQ; q++) begin
            if (need_refill[q] && is_rt[q] && !pick_ok) begin
                pick_ok = 1'b1;  pick_q = Q_W'(q);
            end
        end
        for (int q = 0; q < NQ; q++) begin
            if (need_refill[q] && !pick_ok) begin
                pick_ok = 1'b1;  pick_q = Q_W'(q);
            end
        end
        space = FULL - level[pick_q];
        burst = (remaining[pick_q] < AV_W'(space)) ? LVL_W'(remaining[pick_q]) : space;
    end

    // Engine sequencing: idle -> issue one read -> wait for its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FE_IDLE;
            tgt   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                FE_IDLE: if (pick_ok && !hold) begin
                    tgt   <= pick_q;
                    cnt   <= burst;
                    state <= FE_ISSUE;
                end
                FE_ISSUE: state <= FE_WAIT;
                FE_WAIT: if (mem_rd_valid) begin
                    cnt   <= cnt - LVL_W'(1);
                    state <= (cnt == LVL_W'(1)) ? FE_IDLE : FE_ISSUE;
                end
                default: state <= FE_IDLE;
            endcase
        end
    end

    assign mem_rd_en  = (state == FE_ISSUE);
    assign mem_rd_if  = owner[tgt];
    assign mem_rd_idx = next_idx[tgt];

    // Per-queue strobes for data write and "being filled".
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            filling[q] = (state != FE_IDLE) && (tgt == Q_W'(q));
            wr_sel[q]  = (state == FE_WAIT) && mem_rd_valid && (tgt == Q_W'(q));
        end
    end

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_read_within_avail_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (remaining[tgt] != '0));
endmodule

// File: rtl/desc_queue_alloc.sv
// Shared descriptor queue allocator (top).
// What it does: lends NUM_Q on-chip queues to NUM_IF descriptor rings,
// resolves requests (hit, allocate, flush, busy), drives the shared fetch
// engine and serves per-interface pops.
// Assumes: a request is held stable until req_ack; the interface losing its
// queue is not popped in the cycle of reassignment; one read response per read.
module desc_queue_alloc #(
    parameter int NUM_Q   = 4,
    parameter int NUM_IF  = 8,
    parameter int Q_DEPTH = 8,
    parameter int DESC_W  = 32,
    parameter int PRIO_W  = 2,
    parameter int IDX_W   = 16,
    parameter int AV_W    = 8,
    localparam int IF_W   = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
    localparam int LVL_W  = $clog2(Q_DEPTH + 1),
    localparam int Q_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IF_W-1:0]   req_if,
    input  logic              req_rt,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [LVL_W-1:0]  req_thresh,
    input  logic [IDX_W-1:0]  req_start,
    input  logic [AV_W-1:0]   req_avail,
    output logic              req_ack,
    output logic              req_busy,
    output logic              flush_valid,
    output logic [IF_W-1:0]   flush_if,
    output logic [IDX_W-1:0]  flush_idx,
    output logic              mem_rd_en,
    output logic [IF_W-1:0]   mem_rd_if,
    output logic [IDX_W-1:0]  mem_rd_idx,
    input  logic              mem_rd_valid,
    input  logic [DESC_W-1:0] mem_rd_data,
    input  logic              pop_en,
    input  logic [IF_W-1:0]   pop_if,
    output logic              pop_valid,
    output logic [DESC_W-1:0] pop_desc
);
    logic [NUM_Q-1:0]              owned, is_rt, need_refill, filling, wr_sel;
    logic [NUM_Q-1:0]              alloc_en, hit_en, q_pop, req_match;
    logic [NUM_Q-1:0][IF_W-1:0]    owner;
    logic [NUM_Q-1:0][PRIO_W-1:0]  prio;
    logic [NUM_Q-1:0][LVL_W-1:0]   level;
    logic [NUM_Q-1:0][AV_W-1:0]    remaining;
    logic [NUM_Q-1:0][IDX_W-1:0]   next_idx;
    logic [NUM_Q-1:0][DESC_W-1:0]  head_data;
    logic                          hit, alloc_ok, grant_new;
    logic [Q_W-1:0]                hit_q, alloc_q;

    dqa_victim_sel #(
        .NQ(NUM_Q), .IF_W(IF_W), .PRIO_W(PRIO_W), .LVL_W(LVL_W)
    ) i_sel (
        .owned(owned), .is_rt(is_rt), .filling(filling), .owner(owner),
        .prio(prio), .level(level), .req_if(req_if), .req_prio(req_prio),
        .hit(hit), .hit_q(hit_q), .alloc_ok(alloc_ok), .alloc_q(alloc_q)
    );

    // Request outcome: hit, fresh allocation (possibly flushing), or wait.
    assign grant_new   = req_valid && !hit && alloc_ok;
    assign req_ack     = req_valid && (hit || alloc_ok);
    assign req_busy    = req_valid && !hit && !alloc_ok;
    assign flush_valid = grant_new && owned[alloc_q];
    assign flush_if    = owner[alloc_q];
    assign flush_idx   = next_idx[alloc_q] - IDX_W'(level[alloc_q]);

    // Per-queue control strobes and pop routing.
    always_comb begin
        pop_valid = 1'b0;
        pop_desc  = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            alloc_en[q]  = grant_new && (alloc_q == Q_W'(q));
            hit_en[q]    = req_valid && hit && (hit_q == Q_W'(q));
            req_match[q] = owned[q] && (owner[q] == req_if);
            q_pop[q]     = pop_en && owned[q] && (owner[q] == pop_if);
            if (owned[q] && (owner[q] == pop_if) && (level[q] != '0)) begin
                pop_valid = 1'b1;
                pop_desc  = head_data[q];
            end
        end
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        dqa_queue #(
            .DEPTH(Q_DEPTH), .DESC_W(DESC_W), .IF_W(IF_W), .PRIO_W(PRIO_W),
            .IDX_W(IDX_W), .AV_W(AV_W)
        ) i_queue (
            .clk(clk), .rst_n(rst_n),
            .alloc_en(alloc_en[g]), .hit_en(hit_en[g]),
            .cfg_if(req_if), .cfg_rt(req_rt), .cfg_prio(req_prio),
            .cfg_thresh(req_thresh), .cfg_start(req_start), .cfg_avail(req_avail),
            .wr_en(wr_sel[g]), .wr_data(mem_rd_data), .pop_en(q_pop[g]),
            .owned(owned[g]), .owner(owner[g]), .is_rt(is_rt[g]), .prio(prio[g]),
            .level(level[g]), .remaining(remaining[g]), .next_idx(next_idx[g]),
            .head_data(head_data[g]), .need_refill(need_refill[g])
        );
    end

    dqa_fetch_eng #(
        .NQ(NUM_Q), .DEPTH(Q_DEPTH), .IF_W(IF_W), .IDX_W(IDX_W),
        .AV_W(AV_W), .LVL_W(LVL_W)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n), .hold(grant_new),
        .need_refill(need_refill), .is_rt(is_rt), .level(level),
        .remaining(remaining), .next_idx(next_idx), .owner(owner),
        .mem_rd_valid(mem_rd_valid), .mem_rd_en(mem_rd_en),
        .mem_rd_if(mem_rd_if), .mem_rd_idx(mem_rd_idx),
        .wr_sel(wr_sel), .filling(filling)
    );

    assert_unique_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(req_match));

    assert_busy_no_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |-> (&owned));

    assert_flush_not_filling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_new |-> !(|(alloc_en & filling)));
endmodule

// File: tb/test_desc_queue_alloc.sv
`timescale 1ns/1ps
module test_desc_queue_alloc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_if = '0;
    logic        req_rt = 1'b0;
    logic [1:0]  req_prio = '0;
    logic [3:0]  req_thresh = '0;
    logic [15:0] req_start = '0;
    logic [7:0]  req_avail = '0;
    logic        req_ack, req_busy, flush_valid;
    logic [2:0]  flush_if;
    logic [15:0] flush_idx;
    logic        mem_rd_en;
    logic [2:0]  mem_rd_if;
    logic [15:0] mem_rd_idx;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        pop_en = 1'b0;
    logic [2:0]  pop_if = '0;
    logic        pop_valid;
    logic [31:0] pop_desc;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int rd_cnt [8];
    int last_idx [8];

    always #2 clk = ~clk;

    desc_queue_alloc i_desc_queue_alloc (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_if(req_if), .req_rt(req_rt), .req_prio(req_prio),
        .req_thresh(req_thresh), .req_start(req_start), .req_avail(req_avail),
        .req_ack(req_ack), .req_busy(req_busy),
        .flush_valid(flush_valid), .flush_if(flush_if), .flush_idx(flush_idx),
        .mem_rd_en(mem_rd_en), .mem_rd_if(mem_rd_if), .mem_rd_idx(mem_rd_idx),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .pop_en(pop_en), .pop_if(pop_if), .pop_valid(pop_valid), .pop_desc(pop_desc)
    );

    function automatic logic [31:0] desc_of(input int ifn, input int idx);
        return {8'(ifn), 8'hC3, 16'(idx)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Memory model: one response per read strobe, two edges later.
    initial begin
        bit pend = 0;
        int pif = 0;
        int pidx = 0;
        for (int i = 0; i < 8; i++) begin rd_cnt[i] = 0; last_idx[i] = -1; end
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pend) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = desc_of(pif, pidx);
                pend = 0;
            end else if (mem_rd_en) begin
                pend = 1;
                pif  = int'(mem_rd_if);
                pidx = int'(mem_rd_idx);
                rd_cnt[pif]++;
                last_idx[pif] = pidx;
            end
        end
    end

    // Raise a request and wait for its acknowledge; report cycle count and flush.
    task automatic send_req(input int ifn, input bit rt, input int pr, input int thr,
                            input int start, input int avail, output int waited,
                            output int fl, output int fif, output int fidx);
        @(negedge clk);
        req_valid = 1'b1; req_if = 3'(ifn); req_rt = rt; req_prio = 2'(pr);
        req_thresh = 4'(thr); req_start = 16'(start); req_avail = 8'(avail);
        waited = 0; fl = 0; fif = -1; fidx = -1;
        #1;
        while (!req_ack && waited < 50) begin
            @(negedge clk); #1; waited++;
        end
        fl = int'(flush_valid); fif = int'(flush_if); fidx = int'(flush_idx);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pop_one(input int ifn, output int vld, output int d);
        @(negedge clk);
        pop_en = 1'b1; pop_if = 3'(ifn);
        #1;
        vld = int'(pop_valid); d = int'(pop_desc);
        @(negedge clk);
        pop_en = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input int ifn, input int idx);
        int v, d;
        pop_one(ifn, v, d);
        chk({tag, " pop_valid"}, v, 1);
        chk({tag, " pop_desc"}, d, int'(desc_of(ifn, idx)));
    endtask

    task automatic t_reset();
        #1;
        chk("R1 req_ack", int'(req_ack), 0);
        chk("R1 req_busy", int'(req_busy), 0);
        chk("R1 flush_valid", int'(flush_valid), 0);
        chk("R1 mem_rd_en", int'(mem_rd_en), 0);
        for (int i = 0; i < 8; i++) begin
            pop_if = 3'(i); #0.1;
            chk("R1 pop_valid", int'(pop_valid), 0);
        end
    endtask

    task automatic t_alloc_fetch();
        int w, fl, fi, fx;
        send_req(1, 0, 1, 2, 100, 20, w, fl, fi, fx);
        chk("R2 ack same cycle", w, 0);
        chk("R2 no flush", fl, 0);
        idle(40);
        chk("R3 reads fill queue", rd_cnt[1], 8);
        chk("R3 last index", last_idx[1], 107);
    endtask

    task automatic t_threshold();
        for (int i = 0; i < 3; i++) pop_expect("R4", 1, 100 + i);
        idle(30);
        chk("R6 no refill above threshold", rd_cnt[1], 8);
        for (int i = 3; i < 6; i++) pop_expect("R4", 1, 100 + i);
        idle(30);
        chk("R6 refill at threshold", rd_cnt[1], 14);
        chk("R6 refill last index", last_idx[1], 113);
        pop_expect("R6 order", 1, 106);
    endtask

    task automatic t_ignore();
        int v, d;
        pop_one(5, v, d);
        chk("R13 pop unheld", v, 0);
        pop_expect("R13 head unchanged", 1, 107);
    endtask

    task automatic t_avail();
        int w, fl, fi, fx, v, d;
        send_req(2, 0, 1, 0, 50, 3, w, fl, fi, fx);
        chk("R2 second alloc no flush", fl, 0);
        idle(30);
        chk("R12 reads bounded by avail", rd_cnt[2], 3);
        for (int i = 0; i < 3; i++) pop_expect("R4", 2, 50 + i);
        pop_one(2, v, d);
        chk("R13 pop empty", v, 0);
        idle(10);
        chk("R12 no read when ring exhausted", rd_cnt[2], 3);
        send_req(2, 0, 1, 0, 999, 2, w, fl, fi, fx);
        chk("R5 hit ack same cycle", w, 0);
        chk("R5 hit no flush", fl, 0);
        idle(20);
        chk("R5 added avail fetched", rd_cnt[2], 5);
        chk("R5 resumes ring position", last_idx[2], 54);
        pop_expect("R5", 2, 53);
        pop_expect("R5", 2, 54);
    endtask

    task automatic t_rt();
        int w, fl, fi, fx;
        send_req(3, 1, 3, 0, 0, 30, w, fl, fi, fx);
        chk("R2 rt alloc no flush", fl, 0);
        idle(40);
        chk("R7 rt filled", rd_cnt[3], 8);
        pop_expect("R7", 3, 0);
        idle(20);
        chk("R7 rt topped up", rd_cnt[3], 9);
        chk("R7 rt index", last_idx[3], 8);
    endtask

    task automatic t_victims();
        int w, fl, fi, fx;
        send_req(4, 0, 0, 0, 10, 4, w, fl, fi, fx);
        chk("R9 free queue first", fl, 0);
        idle(20);
        chk("R3 if4 reads", rd_cnt[4], 4);
        send_req(5, 0, 2, 1, 200, 10, w, fl, fi, fx);
        chk("R9 inactive taken flush", fl, 1);
        chk("R10 flushed if", fi, 2);
        chk("R10 resume index", fx, 55);
        idle(40);
        chk("R3 if5 reads", rd_cnt[5], 8);
        pop_expect("R4", 4, 10);
        send_req(6, 0, 2, 0, 300, 2, w, fl, fi, fx);
        chk("R9 lowest priority flush", fl, 1);
        chk("R9 lowest priority if", fi, 4);
        chk("R10 resume index after pop", fx, 11);
        idle(20);
        chk("R3 if6 reads", rd_cnt[6], 2);
    endtask

    task automatic t_busy();
        int v, d, bz;
        @(negedge clk);
        req_valid = 1'b1; req_if = 3'd7; req_rt = 1'b0; req_prio = 2'd1;
        req_thresh = 4'd0; req_start = 16'd400; req_avail = 8'd1;
        bz = 0;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (req_busy && !req_ack) bz++;
            @(negedge clk);
        end
        chk("R11 busy while none eligible", bz, 6);
        pop_expect("R11", 6, 300);
        pop_expect("R11", 6, 301);
        #1;
        chk("R11 ack once eligible", int'(req_ack), 1);
        chk("R10 flush on grant", int'(flush_valid), 1);
        chk("R10 flushed if6", int'(flush_if), 6);
        chk("R10 if6 resume", int'(flush_idx), 302);
        @(negedge clk);
        req_valid = 1'b0;
        pop_if = 3'd3; #1;
        chk("R8 rt queue kept", int'(pop_valid), 1);
        idle(20);
        chk("R3 if7 read", rd_cnt[7], 1);
        chk("R3 if7 index", last_idx[7], 400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_alloc_fetch();
        t_threshold();
        t_ignore();
        t_avail();
        t_rt();
        t_victims();
        t_busy();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule